// File: doc/BRIEF.md
# I2C Target Address Front End

This block is the receive side of an I2C target, run entirely from the system clock. It brings the SCL and SDA lines into the clock domain and watches them for START and STOP conditions. After a START it collects the seven address bits and the direction bit. When the address equals a configured value, it pulls SDA low during the ninth clock to acknowledge. For a write, it then takes in data bytes one after another and acknowledges each of them.

SDA is handled as an open-drain line. The block never drives a high level. It only asks for SDA to be pulled low, through an enable output that the pad logic uses. Each accepted data byte is presented with a one-cycle strobe. A match flag and a direction flag stay valid from the address acknowledge until the next START or STOP.

A START is acted on in any state and from any bit position, and a STOP returns the block to idle. A transfer that the controller abandons partway through a byte therefore leaves nothing behind. Read-data transmission, clock stretching, ten-bit addressing and controller operation are not part of the block.

Top module: `i2c_tgt_frontend`

## Requirements
- R1: After reset, `sda_pull_low`, `rx_strobe`, `addr_hit` and `dir_read` are all 0.
- R2: A START (SDA falling while SCL is high) begins a new address phase. This holds in every state, including a repeated START with no STOP before it, and it clears `addr_hit` and `dir_read`.
- R3: Address bits are sampled on SCL rising edges, most significant bit first. The eighth bit is the direction, where 1 means read. When bits 7..1 of that first byte equal `own_addr`:
  - `sda_pull_low` rises on the SCL falling edge after the eighth bit and falls on the SCL falling edge that ends the ninth clock.
  - `addr_hit` goes to 1.
  - `dir_read` takes the direction bit.
- R4: When the address does not match, SDA is not pulled low and no byte is strobed until the next START.
- R5: On a matched write, each following byte is sampled MSB first. On its eighth SCL rising edge, `rx_data` receives the byte and `rx_strobe` is high for one clock. The byte is then acknowledged as in R3.
- R6: If `rx_ready` is 0 at the eighth rising edge of a data byte, that byte gets no acknowledge and no strobe. The block stays silent until the next START or STOP.
- R7: A STOP (SDA rising while SCL is high) returns the block to idle. It clears `addr_hit` and `dir_read` and releases SDA.
- R8: A START that arrives in the middle of a byte throws away the partial bits. The address that follows is decoded from scratch.
- R9: On a matched read, the address byte is acknowledged and `dir_read` is 1. After that the block neither pulls SDA low nor strobes any byte until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| own_addr | input | 7 | Address this target answers to |
| rx_ready | input | 1 | 1 when the consumer can take another byte |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| sda_pull_low | output | 1 | Open-drain enable; 1 pulls SDA low |
| rx_data | output | 8 | Last received write byte |
| rx_strobe | output | 1 | One-cycle pulse when `rx_data` is new |
| addr_hit | output | 1 | Address matched in the current transfer |
| dir_read | output | 1 | Direction bit of the matched address (1 = read) |

## Verification
The bench builds the block with the default of two synchroniser stages. Each quarter of an SCL period lasts ten system clocks, so the synchroniser and edge-detect latency is well inside every SCL phase. With that margin, every acknowledge can be sampled on the line at SCL high, and the release of SDA can be checked one quarter-period after the ninth falling edge. The timing also lets a repeated START be placed three bits into a data byte, which exercises the abort path at an arbitrary bit position.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared widths and the receive-engine state type for the
// I2C target front end. Assumes 7-bit addressing and 8-bit bytes.
package i2c_tgt_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        RX_IDLE     = 3'd0,
        RX_ADDR     = 3'd1,
        RX_ADDR_ACK = 3'd2,
        RX_DATA     = 3'd3,
        RX_DATA_ACK = 3'd4,
        RX_MUTE     = 3'd5
    } rx_state_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
// Synchroniser: moves the sensed bus lines into the system clock domain.
// Each line gets its own chain of STAGES flops. The chains reset to 1,
// the idle bus level, so that no edge appears when reset is released.
module i2c_tgt_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_in,
    output logic [LINES-1:0] sync_out
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;

        // Shift the raw level through the flop chain of this line.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw_in[g]};
        end

        assign sync_out[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/i2c_tgt_cond.sv
// Bus condition detector. It works on the synchronised SCL and SDA
// levels and produces single-cycle SCL edges and START/STOP events.
// It assumes that a legal SDA change happens only while SCL is low, so
// an SDA change while SCL is high on two samples is a START or a STOP.
module i2c_tgt_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic scl_d;
    logic sda_d;

    // Keep the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Decode edges and bus conditions from the current and previous levels.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_evt = scl_s & scl_d & sda_d & ~sda_s;
        stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2c_tgt_engine.sv
// Receive engine: shifts in the address and data bytes, decides whether
// to acknowledge, and drives the open-drain pull-low enable.
// A START overrides every state and a STOP returns to idle. Apart from
// those two events, changes take place only on SCL edges.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              rx_ready,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    output logic              sda_pull_low,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_strobe,
    output logic              addr_hit,
    output logic              dir_read
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    rx_state_t         state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] full_byte;
    logic              last_rise;

    // The complete byte as seen on the final rising edge of the byte.
    always_comb begin
        full_byte = {shreg[BYTE_W-2:0], sda_lvl};
        last_rise = scl_rise && (bit_cnt == LAST_BIT);
    end

    // Main sequencer: START first, then STOP, then the per-state work.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= RX_IDLE;
            bit_cnt      <= '0;
            shreg        <= '0;
            sda_pull_low <= 1'b0;
            rx_data      <= '0;
            rx_strobe    <= 1'b0;
            addr_hit     <= 1'b0;
            dir_read     <= 1'b0;
        end else begin
            rx_strobe <= 1'b0;
            if (start_evt) begin
                state        <= RX_ADDR;
                bit_cnt      <= '0;
                sda_pull_low <= 1'b0;
                addr_hit     <= 1'b0;
                dir_read     <= 1'b0;
            end else if (stop_evt) begin
                state        <= RX_IDLE;
                bit_cnt      <= '0;
                sda_pull_low <= 1'b0;
                addr_hit     <= 1'b0;
                dir_read     <= 1'b0;
            end else begin
                unique case (state)
                    RX_IDLE: begin
                        sda_pull_low <= 1'b0;
                    end
                    RX_ADDR: begin
                        if (scl_rise) begin
                            shreg   <= full_byte;
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (last_rise) begin
                            bit_cnt <= '0;
                            if (full_byte[BYTE_W-1:1] == own_addr) begin
                                state    <= RX_ADDR_ACK;
                                addr_hit <= 1'b1;
                                dir_read <= full_byte[0];
                            end else begin
                                state <= RX_MUTE;
                            end
                        end
                    end
                    RX_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (!sda_pull_low) begin
                                sda_pull_low <= 1'b1;
                            end else begin
                                sda_pull_low <= 1'b0;
                                state        <= dir_read ? RX_MUTE : RX_DATA;
                            end
                        end
                    end
                    RX_DATA: begin
                        if (scl_rise) begin
                            shreg   <= full_byte;
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (last_rise) begin
                            bit_cnt <= '0;
                            if (rx_ready) begin
                                rx_data   <= full_byte;
                                rx_strobe <= 1'b1;
                                state     <= RX_DATA_ACK;
                            end else begin
                                state <= RX_MUTE;
                            end
                        end
                    end
                    RX_DATA_ACK: begin
                        if (scl_fall) begin
                            if (!sda_pull_low) begin
                                sda_pull_low <= 1'b1;
                            end else begin
                                sda_pull_low <= 1'b0;
                                state        <= RX_DATA;
                            end
                        end
                    end
                    RX_MUTE: begin
                        sda_pull_low <= 1'b0;
                    end
                    default: begin
                        state        <= RX_IDLE;
                        sda_pull_low <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R2: a START always restarts address reception with flags cleared.
    p_start_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == RX_ADDR && !sda_pull_low && !addr_hit && bit_cnt == '0));

    // R7: a STOP returns to idle with SDA released and flags cleared.
    p_stop_idles_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !start_evt) |=> (state == RX_IDLE && !sda_pull_low && !addr_hit && !dir_read));

    // R3: the acknowledge drive begins only while SCL is low.
    p_ack_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_low) |-> !scl_lvl);

    // R4: an unmatched address never pulls SDA low.
    p_silent_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_MUTE && !addr_hit) |-> !sda_pull_low);

    // R5: a strobe is given only inside a matched write.
    p_strobe_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> (addr_hit && !dir_read));

    // R6: a data byte refused by the consumer is neither strobed nor acked.
    p_refuse_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_DATA && last_rise && !rx_ready && !start_evt && !stop_evt)
        |=> (!rx_strobe && state == RX_MUTE));

endmodule

// File: rtl/i2c_tgt_frontend.sv
// I2C target address front end (top). It synchronises the bus lines,
// detects the bus conditions and runs the receive engine. SDA is
// treated as open drain: sda_pull_low = 1 asks the pad to drive low.
// Assumes the system clock is several times faster than SCL, so that
// each SCL phase lasts longer than SYNC_STAGES + 2 system clocks.
module i2c_tgt_frontend
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              rx_ready,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull_low,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_strobe,
    output logic              addr_hit,
    output logic              dir_read
);

    logic [1:0] line_sync;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_evt;
    logic       stop_evt;

    i2c_tgt_sync #(
        .LINES  (2),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   ({scl_in, sda_in}),
        .sync_out (line_sync)
    );

    i2c_tgt_cond i_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (line_sync[1]),
        .sda_s     (line_sync[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_tgt_engine i_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .own_addr     (own_addr),
        .rx_ready     (rx_ready),
        .scl_lvl      (line_sync[1]),
        .sda_lvl      (line_sync[0]),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_evt    (start_evt),
        .stop_evt     (stop_evt),
        .sda_pull_low (sda_pull_low),
        .rx_data      (rx_data),
        .rx_strobe    (rx_strobe),
        .addr_hit     (addr_hit),
        .dir_read     (dir_read)
    );

endmodule

// File: tb/test_i2c_tgt_frontend.sv
// Scoreboard bench: the controller tasks push the bytes that should be
// strobed into a queue, and a monitor pops and compares each strobe.
module test_i2c_tgt_frontend;

    localparam int Q = 10;          // system clocks per quarter SCL period
    localparam logic [6:0] OWN = 7'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_ready = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_pull_low;
    logic [7:0] rx_data;
    logic       rx_strobe;
    logic       addr_hit;
    logic       dir_read;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q[$];
    logic       drive_seen = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull_low;

    i2c_tgt_frontend i_i2c_tgt_frontend (
        .clk          (clk),
        .rst_n        (rst_n),
        .own_addr     (OWN),
        .rx_ready     (rx_ready),
        .scl_in       (scl_m),
        .sda_in       (sda_line),
        .sda_pull_low (sda_pull_low),
        .rx_data      (rx_data),
        .rx_strobe    (rx_strobe),
        .addr_hit     (addr_hit),
        .dir_read     (dir_read)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each strobe against the scoreboard queue (R5).
    always @(negedge clk) begin
        if (sda_pull_low) drive_seen <= 1'b1;
        if (rst_n && rx_strobe) begin
            if (exp_q.size() == 0) begin
                chk("R5 unexpected strobe", {24'h0, rx_data}, 32'hFFFF_FFFF);
            end else begin
                chk("R5 strobed byte", {24'h0, rx_data}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic bus_bit(input logic b, output logic seen);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(Q);
        seen = sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    // Send eight bits MSB first, release SDA for the ninth, return its level.
    task automatic bus_byte(input logic [7:0] v, output logic ack_lvl);
        logic dummy;
        for (int i = 7; i >= 0; i--) bus_bit(v[i], dummy);
        bus_bit(1'b1, ack_lvl);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic ack;
        logic dummy;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1: reset state
        chk("R1 pull low", sda_pull_low, 0);
        chk("R1 strobe", rx_strobe, 0);
        chk("R1 addr_hit", addr_hit, 0);
        chk("R1 dir_read", dir_read, 0);

        // R3/R5: matched write of two bytes
        bus_start();
        bus_byte({OWN, 1'b0}, ack);
        chk("R3 address ack", ack, 0);
        chk("R3 addr_hit", addr_hit, 1);
        chk("R3 dir_read write", dir_read, 0);
        chk("R3 released after ninth", sda_pull_low, 0);
        exp_q.push_back(8'hA5);
        bus_byte(8'hA5, ack);
        chk("R5 data ack 1", ack, 0);
        exp_q.push_back(8'h3C);
        bus_byte(8'h3C, ack);
        chk("R5 data ack 2", ack, 0);
        chk("R5 released after data", sda_pull_low, 0);
        bus_stop();
        // R7: stop clears flags
        chk("R7 addr_hit cleared", addr_hit, 0);
        chk("R7 released", sda_pull_low, 0);

        // R4: wrong address stays silent
        drive_seen = 1'b0;
        bus_start();
        bus_byte({7'h11, 1'b0}, ack);
        chk("R4 no address ack", ack, 1);
        chk("R4 addr_hit low", addr_hit, 0);
        bus_byte(8'h00, ack);
        chk("R4 no data ack", ack, 1);
        chk("R4 never pulled", drive_seen, 0);
        bus_stop();

        // R9: matched read acks then goes silent
        bus_start();
        bus_byte({OWN, 1'b1}, ack);
        chk("R9 read address ack", ack, 0);
        chk("R9 dir_read", dir_read, 1);
        drive_seen = 1'b0;
        bus_byte(8'hFF, ack);
        chk("R9 silent after ack", drive_seen, 0);
        bus_stop();
        chk("R7 dir_read cleared", dir_read, 0);

        // R6: consumer not ready, byte refused
        bus_start();
        bus_byte({OWN, 1'b0}, ack);
        chk("R6 address ack", ack, 0);
        rx_ready = 1'b0;
        bus_byte(8'h77, ack);
        chk("R6 refused nack", ack, 1);
        drive_seen = 1'b0;
        rx_ready = 1'b1;
        bus_byte(8'h12, ack);
        chk("R6 silent afterwards", ack, 1);
        chk("R6 never pulled", drive_seen, 0);
        bus_stop();

        // R8: repeated START three bits into a data byte
        bus_start();
        bus_byte({OWN, 1'b0}, ack);
        bus_bit(1'b1, dummy);
        bus_bit(1'b0, dummy);
        bus_bit(1'b1, dummy);
        bus_start();
        bus_byte({OWN, 1'b0}, ack);
        chk("R8 address after abort", ack, 0);
        exp_q.push_back(8'h81);
        bus_byte(8'h81, ack);
        chk("R8 data after abort", ack, 0);

        // R2: repeated START without STOP, to another address
        bus_start();
        chk("R2 flags cleared by START", addr_hit, 0);
        bus_byte({7'h2B, 1'b0}, ack);
        chk("R2 new address decoded", ack, 1);
        bus_stop();

        tick(Q);
        chk("R5 scoreboard drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule